// File: doc/BRIEF.md
# Pipeline Stage Footprint Recorder

This block sits beside one pipeline stage and keeps a short history of the instructions that passed through it. On each cycle where an instruction is present, it stores one compact record. The record holds the instruction's 8-bit tag and a small residue that sums up the 32-bit result the stage produced. The residue is the result reduced modulo 3 (two bits) or modulo 7 (three bits), and a per-cycle select picks which one. Records go into a 16-slot ring that keeps replacing the oldest record with the newest.

An external stop request freezes the ring. From the cycle the request is first seen, nothing is stored again until reset. After the freeze, a slow serial path reads the history out one bit per enable pulse, so the records can be examined offline once a failure has been caught.

Top module: `stage_trace_recorder`

## Requirements
- R1: A record {tag, residue} is stored only on a cycle where `valid` is high and the ring is not frozen. On a cycle with `valid` low, no slot and no pointer changes.
- R2: With `mod7_sel` low, the residue is `value` mod 3, placed in the low two bits of the 3-bit field with the top bit 0. Exact multiples of 3 give 0.
- R3: With `mod7_sel` high, the residue is `value` mod 7, using all three bits. Exact multiples of 7 give 0.
- R4: Slots are filled in order and the write position wraps from the last slot to slot 0. After more than 16 stores, the ring holds the 16 most recent records.
- R5: A cycle with `stop` high stores nothing, even if `valid` is high. The ring then stays frozen, and all later stores are blocked until reset, whatever `stop` does afterwards.
- R6: While frozen and `scan_en` is high, `scan_out` shows the current bit of the current record. Each record is 11 bits wide, with bits 10..3 holding the tag and bits 2..0 the residue, and it is sent most significant bit first. Each cycle with `scan_step` high moves to the next bit, and after bit 0 the next record begins.
- R7: Readout starts at the oldest record. If fewer than 16 stores have occurred, this is the first record stored; otherwise it is the slot after the newest. After the newest record's last bit, readout returns to the oldest record.
- R8: While the ring is not frozen, `scan_out` is 0 and `scan_step` pulses do not move the read position.
- R9: A synchronous `rst` clears the write position, the full indication and the frozen state.
- R10: A cycle with `scan_step` low keeps `scan_out` on the same bit. Lowering `scan_en` returns the read position to the first bit of the oldest record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| valid | input | 1 | An instruction occupies the stage this cycle |
| tag | input | 8 | Instruction identifier |
| value | input | 32 | Stage result to be summarised |
| mod7_sel | input | 1 | 1: modulo-7 residue, 0: modulo-3 residue |
| stop | input | 1 | Post-trigger freeze request |
| scan_en | input | 1 | Serial readout active |
| scan_step | input | 1 | Advance readout by one bit |
| scan_out | output | 1 | Serial readout data |

## Verification
The hardest case to reach is a stop request that arrives on the same cycle as a valid instruction, right after the ring has been filled exactly once. In that state the blocked write would land on the oldest slot and change only which record is read first. The stimulus fills exactly 16 slots, raises `stop` together with `valid` carrying a marker tag, and then keeps storing after `stop` drops. It then reads the whole ring and one extra record, to confirm that the first record is still present and that readout wraps back to it.

// File: rtl/stage_trace_recorder.sv
module stage_trace_recorder #(
  parameter int TAG_W = 8,
  parameter int VAL_W = 32,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             valid,
  input  logic [TAG_W-1:0] tag,
  input  logic [VAL_W-1:0] value,
  input  logic             mod7_sel,
  input  logic             stop,
  input  logic             scan_en,
  input  logic             scan_step,
  output logic             scan_out
);
  localparam int RES_W = 3;
  localparam int ENT_W = TAG_W + RES_W;
  localparam int PTR_W = $clog2(DEPTH);
  localparam int BIT_W = $clog2(ENT_W);
  localparam int CNT_W = PTR_W + 1;

  function automatic logic [31:0] digit_sum(input logic [VAL_W-1:0] x, input int k);
    logic [31:0] s;
    s = '0;
    for (int i = 0; i < VAL_W; i++)
      s += 32'(x[i]) << (i % k);
    return s;
  endfunction

  function automatic logic [31:0] reduce(input logic [VAL_W-1:0] x, input int k);
    logic [31:0] s;
    logic [31:0] m;
    m = (32'd1 << k) - 32'd1;
    s = digit_sum(x, k);
    for (int p = 0; p < 4; p++)
      s = digit_sum(VAL_W'(s), k);
    if (s >= m) s -= m;
    if (s >= m) s -= m;
    return s;
  endfunction

  logic [31:0]      r3, r7;
  logic [RES_W-1:0] res;

  assign r3  = reduce(value, 2);
  assign r7  = reduce(value, 3);
  assign res = mod7_sel ? r7[RES_W-1:0] : {1'b0, r3[1:0]};

  logic [ENT_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr;
  logic             wrapped, frozen;
  logic             wr_go;

  assign wr_go = valid & ~frozen & ~stop;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr  <= '0;
      wrapped <= 1'b0;
      frozen  <= 1'b0;
    end else begin
      if (stop) frozen <= 1'b1;
      if (wr_go) begin
        wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
        if (wr_ptr == PTR_W'(DEPTH - 1)) wrapped <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk)
    if (wr_go) mem[wr_ptr] <= {tag, res};

  logic [CNT_W-1:0] count, rd_off;
  logic [PTR_W-1:0] oldest, rd_idx;
  logic [BIT_W-1:0] rd_bit;
  logic             scan_live, shift;

  assign count     = wrapped ? CNT_W'(DEPTH) : {1'b0, wr_ptr};
  assign oldest    = wrapped ? wr_ptr : '0;
  assign rd_idx    = oldest + rd_off[PTR_W-1:0];
  assign scan_live = frozen & scan_en & (count != '0);
  assign shift     = scan_live & scan_step;

  always_ff @(posedge clk) begin
    if (rst || !scan_live) begin
      rd_off <= '0;
      rd_bit <= '0;
    end else if (shift) begin
      if (rd_bit == BIT_W'(ENT_W - 1)) begin
        rd_bit <= '0;
        rd_off <= (rd_off == count - 1'b1) ? '0 : rd_off + 1'b1;
      end else begin
        rd_bit <= rd_bit + 1'b1;
      end
    end
  end

  assign scan_out = scan_live ? mem[rd_idx][BIT_W'(ENT_W - 1) - rd_bit] : 1'b0;

  AST_STOP_STICKY: assert property (@(posedge clk) disable iff (rst)
    frozen |=> frozen); // R5
  AST_FROZEN_NO_STORE: assert property (@(posedge clk) disable iff (rst)
    frozen |=> $stable(wr_ptr) && $stable(wrapped)); // R5
  AST_IDLE_NO_STORE: assert property (@(posedge clk) disable iff (rst)
    !valid |=> $stable(wr_ptr)); // R1
  AST_STORE_ADVANCES: assert property (@(posedge clk) disable iff (rst)
    (valid && !frozen && !stop) |=> wr_ptr != $past(wr_ptr)); // R1
  AST_WRAP_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    $rose(wrapped) |-> wr_ptr == '0); // R4
  AST_MOD3_RANGE: assert property (@(posedge clk) disable iff (rst)
    !mod7_sel |-> res < 3'd3); // R2
  AST_MOD7_RANGE: assert property (@(posedge clk) disable iff (rst)
    mod7_sel |-> res < 3'd7); // R3
  AST_SCAN_QUIET: assert property (@(posedge clk) disable iff (rst)
    !frozen |-> !scan_out); // R8
endmodule

// File: tb/stage_trace_recorder_bench.sv
`timescale 1ns/1ps
module stage_trace_recorder_bench;
  logic        clk = 0, rst = 1, valid = 0, mod7_sel = 0, stop = 0;
  logic        scan_en = 0, scan_step = 0;
  logic [7:0]  tag = 0;
  logic [31:0] value = 0;
  logic        scan_out;
  int          errors = 0, checks = 0;

  stage_trace_recorder u_stage_trace_recorder (
    .clk(clk), .rst(rst), .valid(valid), .tag(tag), .value(value),
    .mod7_sel(mod7_sel), .stop(stop), .scan_en(scan_en),
    .scan_step(scan_step), .scan_out(scan_out));

  always #5 clk = ~clk;

  // {tag, mod7_sel, value, expected residue}
  localparam logic [43:0] VEC [16] = '{
    {8'h10, 1'b0, 32'd0,         3'd0},
    {8'h11, 1'b0, 32'd3,         3'd0},
    {8'h12, 1'b0, 32'd10,        3'd1},
    {8'h13, 1'b0, 32'hFFFFFFFF,  3'd0},
    {8'h14, 1'b0, 32'h80000000,  3'd2},
    {8'h15, 1'b0, 32'd300000002, 3'd2},
    {8'h16, 1'b0, 32'd5,         3'd2},
    {8'h17, 1'b0, 32'd1,         3'd1},
    {8'h18, 1'b1, 32'd0,         3'd0},
    {8'h19, 1'b1, 32'd49,        3'd0},
    {8'h1A, 1'b1, 32'd13,        3'd6},
    {8'h1B, 1'b1, 32'hFFFFFFFF,  3'd3},
    {8'h1C, 1'b1, 32'h80000000,  3'd2},
    {8'h1D, 1'b1, 32'd700000005, 3'd5},
    {8'h1E, 1'b1, 32'd7000006,   3'd6},
    {8'h1F, 1'b1, 32'd6,         3'd6}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; valid = 0; stop = 0; scan_en = 0; scan_step = 0;
    @(negedge clk); @(negedge clk);
    rst = 0;
  endtask

  task automatic store(input logic [7:0] t, input logic [31:0] v, input logic m);
    @(negedge clk);
    valid = 1; tag = t; value = v; mod7_sel = m;
    @(negedge clk);
    valid = 0;
  endtask

  task automatic pulse_stop();
    @(negedge clk); stop = 1;
    @(negedge clk); stop = 0;
  endtask

  task automatic read_entry(output logic [10:0] e);
    for (int b = 10; b >= 0; b--) begin
      #1 e[b] = scan_out;
      scan_step = 1;
      @(negedge clk);
      scan_step = 0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [10:0] e, first;
    do_reset();
    @(negedge clk); scan_en = 1;
    #1 check(scan_out == 1'b0, "R9 reset not frozen", scan_out, 0);
    scan_en = 0;

    // table walk with an idle cycle, then a stop on a full ring
    for (int i = 0; i < 16; i++) begin
      store(VEC[i][43:36], VEC[i][34:3], VEC[i][35]);
      if (i == 7) begin
        @(negedge clk); valid = 0; tag = 8'h99; value = 32'd7;
      end
    end
    @(negedge clk); valid = 1; tag = 8'hEE; value = 32'd1; stop = 1;
    @(negedge clk); stop = 0; tag = 8'hEF;
    @(negedge clk); valid = 0;
    scan_en = 1;
    for (int i = 0; i < 16; i++) begin
      read_entry(e);
      check(e == {VEC[i][43:36], VEC[i][2:0]},
            VEC[i][35] ? "R3 R6 mod7 record" : "R2 R6 mod3 record", e, {VEC[i][43:36], VEC[i][2:0]});
    end
    read_entry(e);
    check(e == {VEC[0][43:36], VEC[0][2:0]}, "R7 R5 R1 readout wraps to oldest", e, {VEC[0][43:36], VEC[0][2:0]});

    // hold and restart
    scan_en = 0; @(negedge clk); scan_en = 1;
    #1 first[0] = scan_out;
    scan_step = 1; @(negedge clk); scan_step = 0;
    #1 e[0] = scan_out;
    repeat (3) @(negedge clk);
    #1 check(scan_out == e[0], "R10 hold without step", scan_out, e[0]);
    check(first[0] == VEC[0][43], "R10 restart msb", first[0], VEC[0][43]);
    scan_en = 0; @(negedge clk); scan_en = 1;
    read_entry(e);
    check(e == {VEC[0][43:36], VEC[0][2:0]}, "R10 restart at oldest", e, {VEC[0][43:36], VEC[0][2:0]});

    // partial ring, stop cleared by reset
    do_reset();
    store(8'hA0, 32'd4, 1'b0);
    store(8'hA1, 32'd5, 1'b0);
    store(8'hA2, 32'd6, 1'b0);
    @(negedge clk); scan_en = 1;
    for (int k = 0; k < 5; k++) begin
      scan_step = 1; @(negedge clk); scan_step = 0;
      #1 check(scan_out == 1'b0, "R8 quiet before stop", scan_out, 0);
    end
    scan_en = 0;
    pulse_stop();
    @(negedge clk); scan_en = 1;
    read_entry(e); check(e == {8'hA0, 3'd1}, "R9 R7 first stored", e, {8'hA0, 3'd1});
    read_entry(e); check(e == {8'hA1, 3'd2}, "R7 second", e, {8'hA1, 3'd2});
    read_entry(e); check(e == {8'hA2, 3'd0}, "R2 zero multiple", e, {8'hA2, 3'd0});
    read_entry(e); check(e == {8'hA0, 3'd1}, "R7 wrap partial", e, {8'hA0, 3'd1});
    scan_en = 0;

    // overwrite of oldest
    do_reset();
    for (int k = 0; k < 20; k++) store(8'h40 + 8'(k), 32'(k * 13 + 1), 1'b1);
    pulse_stop();
    @(negedge clk); scan_en = 1;
    for (int k = 4; k < 20; k++) begin
      read_entry(e);
      check(e == {8'h40 + 8'(k), 3'((k * 13 + 1) % 7)}, "R4 R3 overwrite", e, {8'h40 + 8'(k), 3'((k * 13 + 1) % 7)});
    end
    scan_en = 0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule